// File: doc/BRIEF.md
# Bus-Mapped Pin Controller with Edge Interrupts

This block is a general-purpose pin peripheral that sits on a Wishbone slave port with 32-bit data. Software sets the value and the drive state of up to 32 pins. Any output bit can be handed over to an auxiliary hardware source. The pin levels can be read back, either sampled on every bus clock or latched only on an edge of an external pad clock. That edge can be the rising or the falling one.

Each pin can raise an interrupt on a chosen transition: rising or falling. Events collect in a sticky status register. A single interrupt line is driven from that register, gated by a global enable held in the control register.

The pad inputs and the external pad clock are first passed through two-flop synchronisers. All logic then runs on the bus clock, so the block has one clock domain. The register index is byte address bits [ADDR_W-1:2]; bits [1:0] are ignored.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero, `pad_out_o` is zero, `pad_oe_n_o` is all ones and `irq_o` is low.
- R2: `pad_oe_n_o` is the bitwise inverse of the drive-enable register (index 2). It follows a write one clock after the write completes.
- R3: Bit i of `pad_out_o` equals `aux_in_i[i]` when bit i of the aux-select register (index 5) is 1, and bit i of the output register (index 1) otherwise. It is registered once.
- R4: While control bit 2 is 0, the input register (index 0) takes the synchronised pad levels on every clock. A pad change is readable no later than the third clock edge after the edge that first samples it.
- R5: While control bit 2 is 1, the input register changes only on a selected edge of the synchronised `pad_clk_i`. Between such edges it holds its value while the pads change.
- R6: Control bit 3 picks the capturing edge: 1 selects the falling edge and 0 selects the rising edge.
- R7: A pin with its enable bit (index 3) set records an event in the sticky status register (index 7). With its polarity bit (index 4) at 1 the event is a low-to-high transition of the synchronised pad; at 0 it is a high-to-low transition. Steady levels record nothing.
- R8: `irq_o` is control bit 0 ANDed with the OR of all status bits, registered. It is high at the fourth rising edge counted from the edge that first samples a triggering pad change. Control bit 1 becomes 1 on any recorded event.
- R9: Writing zero to control drops `irq_o`. A write to status replaces its content. An event arriving at the same edge as a status or control write still sets its bit.
- R10: A cycle with `wb_cyc_i` and `wb_stb_i` high gets a one-clock `wb_ack_o` on the next edge when `wb_sel_i` is all ones. Otherwise it gets a one-clock `wb_err_o` and no register changes.
- R11: Indices 8 and above read zero and ignore writes. Bits above the pin count read zero. Writes to the input register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_sel_i | input | DW/8 | Byte selects; must be all ones |
| wb_adr_i | input | ADDR_W | Byte address |
| wb_dat_i | input | DW | Write data |
| wb_dat_o | output | DW | Read data, valid with ack |
| wb_ack_o | output | 1 | Cycle completed |
| wb_err_o | output | 1 | Cycle rejected |
| irq_o | output | 1 | Interrupt request |
| pad_in_i | input | PINS | Pad input levels |
| aux_in_i | input | PINS | Auxiliary output sources |
| pad_clk_i | input | 1 | External sampling clock |
| pad_out_o | output | PINS | Pad output values |
| pad_oe_n_o | output | PINS | Active-low pad drive enables |

## Verification
The bench aims at one collision: a pin event and a software write to the status register that both land on the same clock edge. It drives a rising pad edge, then times the status-clear write so it completes at the edge where the synchronised transition is detected. The bench then reads status back and expects the new event bit to survive the clear; it also checks the pending flag in control. The same edge race is also reached at random, because random pad and pad-clock activity runs alongside random bus writes, and a per-cycle reference model judges every output.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    RG_IN   = 3'd0,
    RG_OUT  = 3'd1,
    RG_OE   = 3'd2,
    RG_IE   = 3'd3,
    RG_POL  = 3'd4,
    RG_AUX  = 3'd5,
    RG_CTRL = 3'd6,
    RG_STS  = 3'd7
  } reg_sel_e;

  localparam int CTRL_W  = 4;
  localparam int CB_GIE  = 0;
  localparam int CB_PEND = 1;
  localparam int CB_EXT  = 2;
  localparam int CB_FALL = 3;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank_capture.sv
module gpio_bank_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pad_s,
  input  logic         eclk_s,
  input  logic         ext,
  input  logic         fall,
  output logic [N-1:0] in_q
);
  logic eclk_prev;
  logic edge_now;

  always_comb begin
    edge_now = fall ? (~eclk_s & eclk_prev) : (eclk_s & ~eclk_prev);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eclk_prev <= 1'b0;
      in_q      <= '0;
    end else begin
      eclk_prev <= eclk_s;
      if (!ext || edge_now) in_q <= pad_s;
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pad_s,
  input  logic [N-1:0] ie,
  input  logic [N-1:0] pol,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] sts,
  output logic         ev_any
);
  logic [N-1:0] prev_q;
  logic [N-1:0] trig;

  always_comb begin
    trig   = ie & ((pol & pad_s & ~prev_q) | (~pol & ~pad_s & prev_q));
    ev_any = |trig;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      sts    <= '0;
    end else begin
      prev_q <= pad_s;
      sts    <= (wr_en ? wr_data : sts) | trig;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [DW/8-1:0]   wb_sel_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DW-1:0]     wb_dat_i,
  output logic [DW-1:0]     wb_dat_o,
  output logic              wb_ack_o,
  output logic              wb_err_o,
  output logic              irq_o,
  input  logic [PINS-1:0]   pad_in_i,
  input  logic [PINS-1:0]   aux_in_i,
  input  logic              pad_clk_i,
  output logic [PINS-1:0]   pad_out_o,
  output logic [PINS-1:0]   pad_oe_n_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [PINS-1:0]   out_q, oe_q, ie_q, pol_q, aux_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PINS-1:0]   pad_s, in_q, sts_q;
  logic              eclk_s;
  logic              ev_any;

  logic              valid, sel_ok, acc, wr_hit, hit, sts_we;
  logic [IDX_W-1:0]  idx;
  reg_sel_e          rsel;
  logic [DW-1:0]     rdata;

  logic unused_bits;
  assign unused_bits = ^{wb_adr_i[1:0], wb_dat_i};

  // synchronisers
  gpio_bank_sync #(.W(PINS)) u_pad_sync (
    .clk(clk), .rst(rst), .d(pad_in_i), .q(pad_s)
  );
  gpio_bank_sync #(.W(1)) u_clk_sync (
    .clk(clk), .rst(rst), .d(pad_clk_i), .q(eclk_s)
  );

  gpio_bank_capture #(.N(PINS)) u_capture (
    .clk(clk), .rst(rst), .pad_s(pad_s), .eclk_s(eclk_s),
    .ext(ctrl_q[CB_EXT]), .fall(ctrl_q[CB_FALL]), .in_q(in_q)
  );

  gpio_bank_irq #(.N(PINS)) u_irq (
    .clk(clk), .rst(rst), .pad_s(pad_s), .ie(ie_q), .pol(pol_q),
    .wr_en(sts_we), .wr_data(wb_dat_i[PINS-1:0]),
    .sts(sts_q), .ev_any(ev_any)
  );

  // bus decode
  always_comb begin
    valid  = wb_cyc_i & wb_stb_i & ~wb_ack_o & ~wb_err_o;
    sel_ok = &wb_sel_i;
    acc    = valid & sel_ok;
    idx    = wb_adr_i[ADDR_W-1:2];
    hit    = (idx[IDX_W-1:3] == '0);
    rsel   = reg_sel_e'(idx[2:0]);
    wr_hit = acc & wb_we_i & hit;
    sts_we = wr_hit & (rsel == RG_STS);
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (rsel)
        RG_IN:   rdata[PINS-1:0]   = in_q;
        RG_OUT:  rdata[PINS-1:0]   = out_q;
        RG_OE:   rdata[PINS-1:0]   = oe_q;
        RG_IE:   rdata[PINS-1:0]   = ie_q;
        RG_POL:  rdata[PINS-1:0]   = pol_q;
        RG_AUX:  rdata[PINS-1:0]   = aux_q;
        RG_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
        RG_STS:  rdata[PINS-1:0]   = sts_q;
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack_o <= 1'b0;
      wb_err_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= acc;
      wb_err_o <= valid & ~sel_ok;
      wb_dat_o <= (acc & ~wb_we_i) ? rdata : '0;
    end
  end

  // software registers
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      oe_q   <= '0;
      ie_q   <= '0;
      pol_q  <= '0;
      aux_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_hit) begin
        unique case (rsel)
          RG_OUT:  out_q  <= wb_dat_i[PINS-1:0];
          RG_OE:   oe_q   <= wb_dat_i[PINS-1:0];
          RG_IE:   ie_q   <= wb_dat_i[PINS-1:0];
          RG_POL:  pol_q  <= wb_dat_i[PINS-1:0];
          RG_AUX:  aux_q  <= wb_dat_i[PINS-1:0];
          RG_CTRL: ctrl_q <= wb_dat_i[CTRL_W-1:0];
          default: ;
        endcase
      end
      if (ev_any) ctrl_q[CB_PEND] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= ctrl_q[CB_GIE] & (|sts_q);
  end

  // pad outputs, one mux and flop per pin
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out_o[i]  <= 1'b0;
        pad_oe_n_o[i] <= 1'b1;
      end else begin
        pad_out_o[i]  <= aux_q[i] ? aux_in_i[i] : out_q[i];
        pad_oe_n_o[i] <= ~oe_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ack,
  input logic            err,
  input logic            irq,
  input logic [PINS-1:0] oe_n,
  input logic [PINS-1:0] oe_q,
  input logic [PINS-1:0] out_q,
  input logic [PINS-1:0] sts_q,
  input logic            gie,
  input logic            sts_we,
  input logic            ext,
  input logic            eclk_s,
  input logic [PINS-1:0] in_q
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R10

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ack && err)); // R10

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(out_q) && $stable(oe_q))); // R10

  AST_OEN_INVERSE: assert property (@(posedge clk) disable iff (rst)
    oe_n == ~$past(oe_q)); // R2

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie && (sts_q != '0))); // R8

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(sts_we) |-> ((sts_q & $past(sts_q)) == $past(sts_q))); // R7

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(ext) && ($past(eclk_s) == $past(eclk_s, 2))) |-> $stable(in_q)); // R5
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst(rst), .ack(wb_ack_o), .err(wb_err_o), .irq(irq_o),
  .oe_n(pad_oe_n_o), .oe_q(oe_q), .out_q(out_q), .sts_q(sts_q),
  .gie(ctrl_q[CB_GIE]), .sts_we(sts_we), .ext(ctrl_q[CB_EXT]),
  .eclk_s(eclk_s), .in_q(in_q)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0]  sel = 4'hF;
  logic [5:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] dat_o;
  logic        ack, err, irq;
  logic [N-1:0] pad_in = '0, aux_in = '0;
  logic        pad_clk = 1'b0;
  logic [N-1:0] pad_out, pad_oe_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit run_model_chk = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_sel_i(sel), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat_o),
    .wb_ack_o(ack), .wb_err_o(err), .irq_o(irq), .pad_in_i(pad_in),
    .aux_in_i(aux_in), .pad_clk_i(pad_clk), .pad_out_o(pad_out),
    .pad_oe_n_o(pad_oe_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] m_out, m_oe, m_ie, m_pol, m_aux, m_sts, m_in, m_pout, m_oen;
  logic [3:0]   m_ctrl;
  logic         m_irq, m_ack, m_err;
  logic [31:0]  m_dat;
  logic [N-1:0] hist_p[3];
  logic         hist_c[3];

  always @(posedge clk) begin
    logic v, full, eg;
    logic [3:0] ix;
    logic [N-1:0] trig, n_out, n_oe, n_ie, n_pol, n_aux, n_sts, n_in;
    logic [3:0] n_ctrl;
    logic [31:0] rd;
    if (rst) begin
      m_out = '0; m_oe = '0; m_ie = '0; m_pol = '0; m_aux = '0; m_sts = '0;
      m_in = '0; m_pout = '0; m_oen = '1; m_ctrl = '0; m_irq = 0;
      m_ack = 0; m_err = 0; m_dat = '0;
      for (int k = 0; k < 3; k++) begin hist_p[k] = '0; hist_c[k] = 0; end
    end else begin
      v    = cyc && stb && !m_ack && !m_err;
      full = (sel == 4'hF);
      ix   = adr[5:2];
      trig = m_ie & ((m_pol & hist_p[1] & ~hist_p[2]) | (~m_pol & ~hist_p[1] & hist_p[2]));
      eg   = m_ctrl[3] ? (!hist_c[1] && hist_c[2]) : (hist_c[1] && !hist_c[2]);
      rd = '0;
      case (ix)
        4'd0: rd = 32'(m_in);
        4'd1: rd = 32'(m_out);
        4'd2: rd = 32'(m_oe);
        4'd3: rd = 32'(m_ie);
        4'd4: rd = 32'(m_pol);
        4'd5: rd = 32'(m_aux);
        4'd6: rd = 32'(m_ctrl);
        4'd7: rd = 32'(m_sts);
        default: rd = '0;
      endcase
      n_out = m_out; n_oe = m_oe; n_ie = m_ie; n_pol = m_pol; n_aux = m_aux;
      n_ctrl = m_ctrl; n_sts = m_sts;
      if (v && full && we) begin
        case (ix)
          4'd1: n_out  = wdat[N-1:0];
          4'd2: n_oe   = wdat[N-1:0];
          4'd3: n_ie   = wdat[N-1:0];
          4'd4: n_pol  = wdat[N-1:0];
          4'd5: n_aux  = wdat[N-1:0];
          4'd6: n_ctrl = wdat[3:0];
          4'd7: n_sts  = wdat[N-1:0];
          default: ;
        endcase
      end
      n_sts = n_sts | trig;
      if (trig != '0) n_ctrl[1] = 1'b1;
      n_in = (!m_ctrl[2] || eg) ? hist_p[1] : m_in;
      m_irq  = m_ctrl[0] && (m_sts != '0);
      m_pout = (m_aux & aux_in) | (~m_aux & m_out);
      m_oen  = ~m_oe;
      m_dat  = (v && full && !we) ? rd : '0;
      m_ack  = v && full;
      m_err  = v && !full;
      m_out = n_out; m_oe = n_oe; m_ie = n_ie; m_pol = n_pol; m_aux = n_aux;
      m_ctrl = n_ctrl; m_sts = n_sts; m_in = n_in;
      hist_p[2] = hist_p[1]; hist_p[1] = hist_p[0]; hist_p[0] = pad_in;
      hist_c[2] = hist_c[1]; hist_c[1] = hist_c[0]; hist_c[0] = pad_clk;
    end
  end

  always @(negedge clk) begin
    if (run_model_chk && !rst) begin
      check("R3 model pad_out", 32'(pad_out), 32'(m_pout));
      check("R2 model pad_oe_n", 32'(pad_oe_n), 32'(m_oen));
      check("R8 model irq", 32'(irq), 32'(m_irq));
      check("R10 model ack", 32'(ack), 32'(m_ack));
      check("R10 model err", 32'(err), 32'(m_err));
      check("R11 model read data", dat_o, m_dat);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus(input int idx, input logic [31:0] d, input logic w,
                     input logic [3:0] s, output logic [31:0] r,
                     output logic a, output logic e);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = 6'(idx << 2); wdat = d; sel = s;
    @(negedge clk);
    r = dat_o; a = ack; e = err;
    cyc = 0; stb = 0; we = 0; sel = 4'hF;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    logic [31:0] r; logic a, e;
    bus(idx, d, 1'b1, 4'hF, r, a, e);
  endtask

  task automatic rd(input int idx, output logic [31:0] r);
    logic a, e;
    bus(idx, 32'h0, 1'b0, 4'hF, r, a, e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] r;
    logic a, e;
    int lat;
    repeat (4) @(negedge clk);
    rst = 0;
    run_model_chk = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe_n", 32'(pad_oe_n), 32'(16'hFFFF));
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(i, r);
      check("R1 register zero", r, 32'h0);
    end

    // R2 drive enables
    wr(2, 32'h0000_A5C3);
    @(negedge clk);
    check("R2 oe inverse", 32'(pad_oe_n), 32'(16'h5A3C));

    // R3 output mux
    wr(1, 32'h0000_1234);
    wr(5, 32'h0000_FF00);
    aux_in = 16'hABCD;
    @(negedge clk);
    check("R3 aux mux", 32'(pad_out), 32'h0000_AB34);

    // R4 free-running sampling
    pad_in = 16'h6C39;
    wait_cyc(3);
    rd(0, r);
    check("R4 input follows pads", r, 32'h0000_6C39);

    // R5 external rising edge capture
    pad_clk = 0;
    wr(6, 32'h4);
    wait_cyc(4);
    pad_in = 16'h1111;
    wait_cyc(2);
    pad_clk = 1;
    wait_cyc(4);
    rd(0, r);
    check("R5 captured on rising edge", r, 32'h0000_1111);
    pad_in = 16'h2222;
    wait_cyc(5);
    rd(0, r);
    check("R5 held between edges", r, 32'h0000_1111);
    pad_clk = 0;
    wait_cyc(5);
    rd(0, r);
    check("R6 falling edge ignored in rising mode", r, 32'h0000_1111);

    // R6 falling edge select
    wr(6, 32'hC);
    pad_clk = 1;
    wait_cyc(4);
    pad_in = 16'h3333;
    wait_cyc(2);
    pad_clk = 0;
    wait_cyc(4);
    rd(0, r);
    check("R6 captured on falling edge", r, 32'h0000_3333);
    pad_in = 16'h4444;
    pad_clk = 1;
    wait_cyc(5);
    rd(0, r);
    check("R6 rising edge ignored in falling mode", r, 32'h0000_3333);
    wr(6, 32'h0);

    // R7 falling-edge events and steady levels
    pad_in = 16'hFFFF;
    wait_cyc(4);
    wr(4, 32'h0);
    wr(3, 32'h0000_00F0);
    wr(7, 32'h0);
    wait_cyc(4);
    rd(7, r);
    check("R7 steady level no event", r, 32'h0);
    pad_in = 16'hFF0F;
    wait_cyc(4);
    rd(7, r);
    check("R7 falling event recorded", r, 32'h0000_00F0);
    pad_in = 16'hFFFF;
    wait_cyc(4);
    rd(7, r);
    check("R7 status sticky, rising ignored", r, 32'h0000_00F0);

    // R8 interrupt latency, rising polarity
    wr(3, 32'h0000_FFFF);
    wr(4, 32'h0000_FFFF);
    pad_in = 16'h0000;
    wait_cyc(4);
    wr(7, 32'h0);
    wr(6, 32'h1);
    wait_cyc(2);
    check("R8 irq low before event", 32'(irq), 32'h0);
    pad_in = 16'h0001;
    lat = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (irq && lat == 0) lat = i;
    end
    check("R8 irq at fourth edge", 32'(lat), 32'd4);
    rd(6, r);
    check("R8 pending flag", r & 32'h2, 32'h2);

    // R9 control clear drops irq
    wr(6, 32'h0);
    wait_cyc(2);
    check("R9 irq low after control zero", 32'(irq), 32'h0);
    wr(7, 32'h0000_0005);
    rd(7, r);
    check("R9 status write replaces", r, 32'h0000_0005);
    wr(7, 32'h0);

    // R9 collision: clear status on the edge that detects an event
    @(negedge clk);
    pad_in = 16'h0009;
    @(negedge clk);
    wr(7, 32'h0);
    rd(7, r);
    check("R9 event wins over clear", r, 32'h0000_0008);
    rd(6, r);
    check("R9 pending set by colliding event", r & 32'h2, 32'h2);

    // R10 byte select not full
    bus(1, 32'h0000_FFFF, 1'b1, 4'h7, r, a, e);
    check("R10 err asserted", 32'(e), 32'h1);
    check("R10 no ack on err", 32'(a), 32'h0);
    rd(1, r);
    check("R10 register unchanged", r, 32'h0000_1234);
    bus(1, 32'h0, 1'b0, 4'hF, r, a, e);
    check("R10 ack on full select", 32'(a), 32'h1);

    // R11 unused addresses and read-only input
    wr(9, 32'hFFFF_FFFF);
    rd(9, r);
    check("R11 unused index reads zero", r, 32'h0);
    rd(1, r);
    check("R11 unused write no effect", r, 32'h0000_1234);
    wr(1, 32'hFFFF_FFFF);
    rd(1, r);
    check("R11 upper bits read zero", r, 32'h0000_FFFF);
    pad_in = 16'h0F0F;
    wait_cyc(4);
    wr(0, 32'h0000_1234);
    rd(0, r);
    check("R11 input write ignored", r, 32'h0000_0F0F);

    // random activity judged by the model every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      pad_in  = N'($urandom);
      aux_in  = N'($urandom);
      pad_clk = 1'($urandom);
      if (($urandom % 3) == 0) begin
        bus($urandom % 16, $urandom, 1'($urandom),
            (($urandom % 5) == 0) ? 4'($urandom) : 4'hF, r, a, e);
      end
    end

    wait_cyc(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule